// File: doc/BRIEF.md
# Request-Driven Comma Word Aligner

This block sits behind a deserializer that delivers 10-bit words with no known word boundary. It joins the newest word with the one before it into a 20-bit window and compares a fixed alignment pattern, and optionally its bitwise inverse, against all ten bit offsets of that window at once. The selected offset is the word boundary, and every output word is cut from the window at that offset.

The boundary moves only while the align request input is high. While the request is held, the aligner jumps to a new offset whenever the pattern turns up at an offset other than the current one. If more than one offset matches, the lowest offset wins. When the request is low, the boundary stays where it is. A pattern-detect flag marks each output word that equals the pattern. A one-cycle sync pulse follows a qualifying detection by three clock cycles. A detection qualifies if the boundary moved on that cycle, or if it is the first detection since the request went high.

Top module: `wa_comma_aligner`

## Requirements
- R1: When `rst_n` is low at a rising edge, after that edge the boundary is offset 0 and `rx_aligned`, `pattern_det` and `sync_status` are all 0.
- R2: Take W(n) as the 20-bit value {word sampled at edge n, word sampled at edge n-1}, with the older word in bits 9:0 and bit 0 the earliest bit. After edge n+1, `rx_aligned` equals bits [k+9:k] of W(n), where k is the boundary chosen at edge n+1.
- R3: After each edge, `pattern_det` is 1 exactly when `rx_aligned` equals the pattern (default 10'b0101111100, 0x17C) or, with inversion matching enabled, its complement (0x283).
- R4: If `align_req` is high, the pattern is absent at the current offset and present at one or more other offsets, the boundary moves to the lowest matching offset. The realigned word appears on `rx_aligned` after that same edge.
- R5: While `align_req` is low, the boundary does not change, whatever the input data.
- R6: If `align_req` is high and the pattern already matches at the current offset, the boundary does not move.
- R7: `sync_status` is high for one cycle, three cycles after `pattern_det` is high on a qualifying cycle. A cycle qualifies when `align_req` was high at its edge and either the boundary moved on that edge or no qualifying cycle has occurred since `align_req` last rose.
- R8: `sync_status` stays low unless a qualifying cycle occurred three cycles earlier. In particular, detections while `align_req` is low never produce a sync pulse.
- R9: The request is level-sensitive. While `align_req` stays high, the boundary can move any number of times, and each move produces its own sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_raw | input | W (10) | Unaligned word from the deserializer, bit 0 earliest |
| align_req | input | 1 | Level-sensitive request that allows the boundary to move |
| rx_aligned | output | W (10) | Word cut at the current boundary |
| pattern_det | output | 1 | The pattern or its inverse is present in `rx_aligned` |
| sync_status | output | 1 | One-cycle pulse, three cycles after a qualifying detection |

## Verification
The assertions assume that `rx_raw`, `align_req` and `rst_n` are synchronous to `clk` and hold still around the rising edge. They also assume that reset is held low for at least one edge before the checks start. The bench changes every input just after the falling edge and keeps reset low for several cycles, both at the start and again mid-run. The random phase mixes free data with rotated copies of the pattern and its inverse, so the boundary really moves. It also holds `align_req` in runs, so both held and toggled requests occur.

// File: rtl/wa_pkg.sv
package wa_pkg;
    // Cycles from a qualifying detection to the sync pulse.
    localparam int unsigned SYNC_LAT = 3;
    // Default comma: positive-disparity K28.5, bit 0 received first.
    localparam logic [9:0] COMMA_DEFAULT = 10'b0101111100;
endpackage

// File: rtl/wa_window_regs.sv
// Captures the incoming word and its predecessor, then presents them as
// one window (older word in the low half). Assumes rx_raw is synchronous to clk.
module wa_window_regs #(
    parameter int W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   rx_raw,
    output logic [2*W-1:0] window
);
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    // Two-word history of the raw stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= rx_raw;
            prev_q <= cur_q;
        end
    end

    assign window = {cur_q, prev_q};
endmodule

// File: rtl/wa_match_bank.sv
// One comparator for each bit offset of the window. A lane reports a hit when
// its slice equals the pattern, or its inverse when INV is set. Purely combinational.
module wa_match_bank #(
    parameter int           W   = 10,
    parameter logic [W-1:0] PAT = '0,
    parameter bit           INV = 1'b1
) (
    input  logic [2*W-1:0] window,
    output logic [W-1:0]   hit
);
    for (genvar k = 0; k < W; k++) begin : g_lane
        logic [W-1:0] slice;
        assign slice = window[k +: W];
        if (INV) begin : g_both
            // Either polarity of the pattern counts.
            assign hit[k] = (slice == PAT) || (slice == ~PAT);
        end else begin : g_plain
            // Only the pattern as given counts.
            assign hit[k] = (slice == PAT);
        end
    end
endmodule

// File: rtl/wa_boundary_ctrl.sv
// Holds the word boundary and decides when it moves. It moves only while
// align_req is high and the current offset does not match, to the lowest
// matching offset. It also flags qualifying detections for the sync pulse.
// Assumes hit is valid in the same cycle.
module wa_boundary_ctrl #(
    parameter int W     = 10,
    parameter int OFF_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_req,
    input  logic [W-1:0]     hit,
    output logic [OFF_W-1:0] off_q,
    output logic [OFF_W-1:0] off_next,
    output logic             det_next,
    output logic             lock_q
);
    logic [OFF_W-1:0] lowest;
    logic             any_hit;
    logic             move;
    logic             lock_next;
    logic             held_q;

    // Priority encoder: the lowest matching offset.
    always_comb begin
        lowest = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hit[k]) lowest = OFF_W'(k);
        end
        any_hit = |hit;
    end

    // Next boundary, and whether this cycle qualifies for a sync pulse.
    always_comb begin
        move      = align_req && any_hit && !hit[off_q];
        off_next  = move ? lowest : off_q;
        det_next  = hit[off_next];
        lock_next = align_req && det_next && (move || !held_q);
    end

    // Boundary, held-request flag and registered qualifying event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            held_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            off_q  <= off_next;
            held_q <= align_req && (held_q || lock_next);
            lock_q <= lock_next;
        end
    end
endmodule

// File: rtl/wa_sync_delay.sv
// Fixed-length delay line for the sync event. The output is the input
// delayed by DEPTH clocks.
module wa_sync_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic evt_out
);
    logic [DEPTH:0] stage;

    assign stage[0] = evt_in;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        // One register stage of the delay line.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[i+1] <= 1'b0;
            else        stage[i+1] <= stage[i];
        end
    end

    assign evt_out = stage[DEPTH];
endmodule

// File: rtl/wa_comma_aligner.sv
// Top of the request-driven comma aligner. Searches a two-word window for the
// pattern at every offset, moves the boundary only under align_req, and
// registers the realigned word, the detect flag and the delayed sync pulse.
// Assumes a single clock domain and a synchronous active-low reset.
module wa_comma_aligner #(
    parameter int           W         = 10,
    parameter logic [W-1:0] PATTERN   = wa_pkg::COMMA_DEFAULT,
    parameter bit           MATCH_INV = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rx_raw,
    input  logic         align_req,
    output logic [W-1:0] rx_aligned,
    output logic         pattern_det,
    output logic         sync_status
);
    localparam int OFF_W = $clog2(W);

    logic [2*W-1:0]   window;
    logic [W-1:0]     hit;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] off_next;
    logic             det_next;
    logic             lock_q;

    wa_window_regs #(.W(W)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_raw (rx_raw),
        .window (window)
    );

    wa_match_bank #(.W(W), .PAT(PATTERN), .INV(MATCH_INV)) u_match (
        .window (window),
        .hit    (hit)
    );

    wa_boundary_ctrl #(.W(W), .OFF_W(OFF_W)) u_bound (
        .clk       (clk),
        .rst_n     (rst_n),
        .align_req (align_req),
        .hit       (hit),
        .off_q     (off_q),
        .off_next  (off_next),
        .det_next  (det_next),
        .lock_q    (lock_q)
    );

    wa_sync_delay #(.DEPTH(wa_pkg::SYNC_LAT)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_in  (lock_q),
        .evt_out (sync_status)
    );

    // Output word and detect flag, both cut at the boundary taking effect this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_aligned  <= '0;
            pattern_det <= 1'b0;
        end else begin
            rx_aligned  <= window[off_next +: W];
            pattern_det <= det_next;
        end
    end
endmodule

// File: rtl/wa_comma_aligner_chk.sv
// Temporal checks on the aligner, bound into every instance of the top module.
module wa_comma_aligner_chk #(
    parameter int           W     = 10,
    parameter logic [W-1:0] PAT   = '0,
    parameter bit           INV   = 1'b1,
    parameter int           OFF_W = $clog2(W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             align_req,
    input logic [OFF_W-1:0] boundary_q,
    input logic [W-1:0]     rx_aligned,
    input logic             pattern_det,
    input logic             sync_status
);
    logic is_pat;
    assign is_pat = (rx_aligned == PAT) || (INV && (rx_aligned == ~PAT));

    assert_offset_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_q < OFF_W'(W));

    assert_detect_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_det |-> is_pat);

    assert_detect_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pattern_det |-> !is_pat);

    assert_move_shows_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_q != $past(boundary_q)) |-> pattern_det);

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !align_req |=> $stable(boundary_q));

    assert_sync_follows_detect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_status |-> $past(pattern_det, wa_pkg::SYNC_LAT));

    assert_sync_needs_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_status |-> $past(align_req, wa_pkg::SYNC_LAT + 1));
endmodule

bind wa_comma_aligner wa_comma_aligner_chk #(
    .W   (W),
    .PAT (PATTERN),
    .INV (MATCH_INV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .align_req   (align_req),
    .boundary_q  (off_q),
    .rx_aligned  (rx_aligned),
    .pattern_det (pattern_det),
    .sync_status (sync_status)
);

// File: tb/wa_comma_aligner_bench.sv
`timescale 1ns/1ps
module wa_comma_aligner_bench;
    localparam logic [9:0] PAT = 10'b0101111100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] rx_raw;
    logic       align_req;
    logic [9:0] rx_aligned;
    logic       pattern_det;
    logic       sync_status;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    // Expected-value state, advanced once per rising edge.
    logic [9:0] e_cur, e_prev, e_out;
    int         e_off;
    logic       e_det, e_held;
    logic [3:0] e_pipe;

    always #2 clk = ~clk;

    wa_comma_aligner u_wa_comma_aligner (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_raw      (rx_raw),
        .align_req   (align_req),
        .rx_aligned  (rx_aligned),
        .pattern_det (pattern_det),
        .sync_status (sync_status)
    );

    function automatic logic [9:0] rotl(input logic [9:0] v, input int k);
        logic [19:0] d;
        d = {v, v} << k;
        return d[19:10];
    endfunction

    function automatic bit is_comma(input logic [9:0] v);
        return (v == PAT) || (v == ~PAT);
    endfunction

    // Updates the expected values from R1..R9 for the edge that just passed.
    task automatic expect_edge();
        logic [19:0] win;
        int          pick;
        bit          moved, lock;
        if (!rst_n) begin
            e_cur = '0; e_prev = '0; e_out = '0; e_off = 0;
            e_det = 0; e_held = 0; e_pipe = '0;
            return;
        end
        win   = {e_cur, e_prev};
        moved = 0;
        if (align_req && !is_comma(win[e_off +: 10])) begin
            pick = -1;
            for (int k = 9; k >= 0; k--) if (is_comma(win[k +: 10])) pick = k;
            if (pick >= 0) begin e_off = pick; moved = 1; end
        end
        e_out  = win[e_off +: 10];
        e_det  = is_comma(e_out);
        lock   = align_req && e_det && (moved || !e_held);
        e_held = align_req && (e_held || lock);
        e_pipe = {e_pipe[2:0], lock};
        e_prev = e_cur;
        e_cur  = rx_raw;
    endtask

    task automatic check_outputs(input string td, input string ts);
        n_checks += 3;
        if (rx_aligned !== e_out) begin
            n_fail++;
            $display("FAIL %s rx_aligned got %h expected %h", td, rx_aligned, e_out);
        end
        if (pattern_det !== e_det) begin
            n_fail++;
            $display("FAIL R3 pattern_det got %b expected %b", pattern_det, e_det);
        end
        if (sync_status !== e_pipe[3]) begin
            n_fail++;
            $display("FAIL %s sync_status got %b expected %b", ts, sync_status, e_pipe[3]);
        end
    endtask

    // One clock: wait for the edge, check at the falling edge; inputs change afterwards.
    task automatic step(input string td, input string ts);
        @(posedge clk);
        @(negedge clk);
        expect_edge();
        check_outputs(td, ts);
    endtask

    task automatic run(input int n, input logic [9:0] w, input logic rq,
                       input string td, input string ts);
        rx_raw = w; align_req = rq;
        for (int i = 0; i < n; i++) step(td, ts);
    endtask

    initial begin
        void'($urandom(32'h0A11_6E5D));
        rst_n = 1'b0; rx_raw = rotl(PAT, 3); align_req = 1'b1;
        for (int i = 0; i < 4; i++) step("R1", "R1");       // reset clears everything
        rst_n = 1'b1;
        run(12, rotl(PAT, 3), 1'b0, "R5", "R8");             // comma at offset 3, no request
        run(12, rotl(PAT, 3), 1'b1, "R4", "R7");             // request: move to 3, sync later
        run(8,  rotl(PAT, 3), 1'b1, "R6", "R6");             // already aligned, no new move
        run(2,  rotl(PAT, 3), 1'b0, "R5", "R8");
        run(8,  rotl(PAT, 3), 1'b1, "R6", "R7");             // re-request while aligned
        run(10, rotl(PAT, 7), 1'b1, "R9", "R9");             // held request, second move
        run(8,  rotl(PAT, 1), 1'b0, "R5", "R8");             // stream shifts, boundary frozen
        run(10, rotl(~PAT, 5), 1'b1, "R4", "R7");            // inverse polarity match
        run(6,  10'h000, 1'b1, "R2", "R8");
        // Random phase: free data mixed with rotated commas, request in runs.
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 16) == 0) align_req = ~align_req;
            case ($urandom % 4)
                0:       rx_raw = rotl(($urandom % 2) ? PAT : ~PAT, int'($urandom % 10));
                default: rx_raw = 10'($urandom);
            endcase
            step("R2", "R7");
        end
        rst_n = 1'b0;
        run(3, 10'($urandom), 1'b1, "R1", "R1");             // mid-run reset
        rst_n = 1'b1;
        run(10, rotl(PAT, 9), 1'b1, "R4", "R7");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule